// File: doc/BRIEF.md
# Pseudo-Static RAM Access Sequencer

This block is a synchronous controller that sits between an on-chip requester and an external asynchronous pseudo-static RAM. The RAM holds 512K bytes and takes its address in a single, non-multiplexed transfer. A requester issues one read or one write at a time over a valid/ready handshake. The sequencer turns each request into a single strobe cycle on the memory pins: an active-low chip enable, an active-low write enable, and one active-low pin that serves as output enable during an access and as a refresh command in standby. It also sets the direction of a split data bus. Read data comes back with a one-cycle valid strobe.

Every memory timing figure is a parameter in nanoseconds, and the block rounds each one up to whole clocks at the configured clock period. After reset the block waits out the power-up pause, then runs a series of dummy read cycles, and only then accepts requests. Refresh scheduling stays outside the block. An external refresh agent raises `refresh_grant` to keep the sequencer from starting a new access while that agent uses the memory pins.

The control is one state machine:
- `ST_PWRUP` waits the power-up pause and then goes to `ST_SETUP`.
- `ST_IDLE` accepts a request and goes to `ST_SETUP`.
- `ST_SETUP` presents the address with chip enable high and goes to `ST_ACTIVE`.
- `ST_ACTIVE` holds chip enable low for the access time and goes to `ST_TAIL`.
- `ST_TAIL` lifts output enable and write enable while chip enable is still low, then goes to `ST_PRECHG`.
- `ST_PRECHG` holds chip enable high. It goes back to `ST_SETUP` while dummy cycles remain, and otherwise to `ST_IDLE`.

Top module: `psram_seq`

## Requirements
- R1: After reset, `busy` is high, `req_ready` is low and chip enable is high for ceil(T_PWR_NS/CLK_NS) cycles. Then N_DUMMY (8) chip-enable pulses run with output enable and write enable held high and no `rsp_valid`. Only after these does `req_ready` rise.
- R2: Each chip-enable low pulse lasts exactly N_CE+1 clocks, where N_CE = max(ceil(70/CLK), ceil(25/CLK), ceil(20/CLK), ceil(70/CLK)-1) with the default timings. This keeps every pulse between 70 ns and 10 µs.
- R3: Chip enable stays high for at least N_PRE+1 clocks between accesses, where N_PRE = max(1, ceil(35/CLK)-1, ceil(115/CLK)-N_CE-2). Consecutive falling edges are at least 115 ns apart.
- R4: `mem_addr` is set at least one clock before chip enable falls and does not change while chip enable is low.
- R5: On a write, write enable is low for the first N_CE clocks of the pulse and rises one clock before chip enable. Output enable stays high throughout. `mem_dq_oe` is high and `mem_dq_out` equals the request data while chip enable is low.
- R6: On a read, output enable is low for the first N_CE clocks of the pulse. The bus is sampled at the clock edge that ends those clocks. `rsp_valid` is high for exactly one clock, the last clock of the chip-enable pulse, and `rsp_rdata` holds the byte stored at the request address.
- R7: Output enable is high on every rising edge of chip enable and throughout standby.
- R8: `req_ready` is high only in `ST_IDLE` with no grant, and `busy` is high in every other state. One accepted request produces exactly one chip-enable pulse.
- R9: While `refresh_grant` is high, `req_ready` is low, no request is accepted and chip enable stays high. A request that is waiting is taken on the first clock after the grant drops.
- R10: `mem_dq_oe` is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address (bits 0-10 row, 11-18 column) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 8 | Read data |
| busy | output | 1 | Initialization or access in progress |
| refresh_grant | input | 1 | External refresh agent owns the memory pins |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable / refresh command, active low |
| mem_dq_out | output | 8 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data from memory |

## Verification
Two events can land on the same clock: the sequencer returning to `ST_IDLE` with a request already waiting, and the refresh agent raising its grant. The bench provokes this by holding `req_valid` high through an earlier access and raising `refresh_grant` on the falling edge just before the precharge ends. The collision is judged to be handled correctly when `req_ready` stays low, no new chip-enable fall appears for as long as the grant is held, and the waiting request starts on the clock after the grant drops. A behavioural memory model in the bench also times every pin edge in nanoseconds, so that any shortened pulse, short precharge or early data sample shows up.

// File: rtl/psram_seq_pkg.sv
`timescale 1ns/1ps
package psram_seq_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_TAIL,
        ST_PRECHG
    } seq_state_t;

    // Round a nanosecond figure up to whole clocks.
    function automatic int cdiv(input int n, input int d);
        return (n + d - 1) / d;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_timer.sv
`timescale 1ns/1ps
module psram_timer #(
    parameter int CW      = 14,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= CW'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/psram_dpath.sv
`timescale 1ns/1ps
module psram_dpath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_write,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q,
    output logic          write_q,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            write_q <= 1'b0;
        end else if (load) begin
            addr_q  <= load_addr;
            data_q  <= load_data;
            write_q <= load_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rsp_data <= dq_in;
        end
    end
endmodule

// File: rtl/psram_seq.sv
`timescale 1ns/1ps
module psram_seq
    import psram_seq_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 10,
    parameter int T_CEA_NS   = 70,
    parameter int T_OEA_NS   = 25,
    parameter int T_CEMIN_NS = 70,
    parameter int T_DW_NS    = 20,
    parameter int T_PRE_NS   = 35,
    parameter int T_RC_NS    = 115,
    parameter int T_PWR_NS   = 100000,
    parameter int N_DUMMY    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    input  logic              refresh_grant,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Clocks of chip enable low before the tail clock.
    localparam int N_CE  = imax(imax(cdiv(T_CEA_NS, CLK_NS), cdiv(T_OEA_NS, CLK_NS)),
                                imax(cdiv(T_DW_NS, CLK_NS), cdiv(T_CEMIN_NS, CLK_NS) - 1));
    // Precharge clocks; the shortest high gap is N_PRE plus the setup clock.
    localparam int N_PRE = imax(1, imax(cdiv(T_PRE_NS, CLK_NS) - 1,
                                        cdiv(T_RC_NS, CLK_NS) - N_CE - 2));
    localparam int N_PWR = imax(1, cdiv(T_PWR_NS, CLK_NS));
    localparam int TW    = $clog2(imax(N_PWR, imax(N_CE, N_PRE)) + 1);
    localparam int DCW   = $clog2(N_DUMMY + 1);

    seq_state_t state, nxt;

    logic           tmr_load, tmr_done;
    logic [TW-1:0]  tmr_val;
    logic           accept, capture, dummy_dec;
    logic [DCW-1:0] dummy_left;
    logic           init_phase;
    logic           write_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    assign init_phase = (dummy_left != '0);

    psram_timer #(.CW(TW), .RST_VAL(N_PWR - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_write (req_write),
        .load_addr  (req_addr),
        .load_data  (req_wdata),
        .capture    (capture),
        .dq_in      (mem_dq_in),
        .addr_q     (addr_q),
        .data_q     (data_q),
        .write_q    (write_q),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_rdata)
    );

    // Next state, timer loads and datapath strobes.
    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        dummy_dec = 1'b0;
        unique case (state)
            ST_PWRUP: begin
                if (tmr_done)
                    nxt = ST_SETUP;
            end
            ST_IDLE: begin
                if (req_valid && !refresh_grant) begin
                    accept = 1'b1;
                    nxt    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(N_CE - 1);
                nxt      = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (tmr_done) begin
                    capture = !write_q && !init_phase;
                    nxt     = ST_TAIL;
                end
            end
            ST_TAIL: begin
                tmr_load = 1'b1;
                tmr_val  = TW'(N_PRE - 1);
                nxt      = ST_PRECHG;
            end
            ST_PRECHG: begin
                if (tmr_done) begin
                    dummy_dec = init_phase;
                    nxt       = (dummy_left > DCW'(1)) ? ST_SETUP : ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register and dummy-cycle count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PWRUP;
            dummy_left <= DCW'(N_DUMMY);
        end else begin
            state <= nxt;
            if (dummy_dec)
                dummy_left <= dummy_left - DCW'(1);
        end
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        mem_ce_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        busy       = 1'b1;
        req_ready  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                req_ready = !refresh_grant;
            end
            ST_ACTIVE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = !write_q;
                mem_oe_n  = write_q || init_phase;
                mem_dq_oe = write_q;
            end
            ST_TAIL: begin
                mem_ce_n  = 1'b0;
                mem_dq_oe = write_q;
            end
            ST_PWRUP, ST_SETUP, ST_PRECHG: begin
            end
            default: begin
            end
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = data_q;
endmodule

// File: rtl/psram_seq_chk.sv
`timescale 1ns/1ps
module psram_seq_chk #(
    parameter int ADDR_W  = 19,
    parameter int N_CE    = 7,
    parameter int N_PRE   = 3,
    parameter int N_DUMMY = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              busy,
    input logic              refresh_grant,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic ce_q;
    int   low_cnt, high_cnt, fall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q     <= 1'b1;
            low_cnt  <= 0;
            high_cnt <= 0;
            fall_cnt <= 0;
        end else begin
            ce_q     <= mem_ce_n;
            low_cnt  <= mem_ce_n ? 0 : low_cnt + 1;
            high_cnt <= !mem_ce_n ? 0 : ((high_cnt < 1000000) ? high_cnt + 1 : high_cnt);
            if (!mem_ce_n && ce_q && fall_cnt < N_DUMMY)
                fall_cnt <= fall_cnt + 1;
        end
    end

    assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_cnt < N_DUMMY) |-> (!req_ready && busy && mem_oe_n && !rsp_valid));

    assert_ce_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ce_n && !ce_q) |-> (low_cnt == N_CE + 1));

    assert_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && ce_q) |-> (high_cnt >= N_PRE + 1));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> $stable(mem_addr));

    assert_write_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_we_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> $past(mem_we_n));

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_in_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!mem_ce_n && mem_oe_n));

    assert_oe_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_ce_n) |-> (mem_oe_n && $past(mem_oe_n)));

    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && mem_ce_n));

    assert_grant_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_grant |-> !req_ready);

    assert_bus_turn_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
endmodule

bind psram_seq psram_seq_chk #(
    .ADDR_W (ADDR_W),
    .N_CE   (N_CE),
    .N_PRE  (N_PRE),
    .N_DUMMY(N_DUMMY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .busy         (busy),
    .refresh_grant(refresh_grant),
    .rsp_valid    (rsp_valid),
    .mem_addr     (mem_addr),
    .mem_ce_n     (mem_ce_n),
    .mem_we_n     (mem_we_n),
    .mem_oe_n     (mem_oe_n),
    .mem_dq_oe    (mem_dq_oe)
);

// File: tb/test_psram_seq.sv
`timescale 1ns/1ps
module test_psram_seq;

    function automatic int cd(input int n, input int d);
        return (n + d - 1) / d;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CLK_NS = 10;
    localparam int NCE    = mx(mx(cd(70, CLK_NS), cd(25, CLK_NS)), mx(cd(20, CLK_NS), cd(70, CLK_NS) - 1));
    localparam int NPRE   = mx(1, mx(cd(35, CLK_NS) - 1, cd(115, CLK_NS) - NCE - 2));
    localparam int NPWR   = cd(100000, CLK_NS);
    localparam int NDUM   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        refresh_grant = 1'b0;
    logic        req_ready, rsp_valid, busy;
    logic [7:0]  rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    always #5 clk = ~clk;

    psram_seq i_psram_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
        .refresh_grant(refresh_grant),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] dflt(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    // ---------------- behavioural memory model ----------------
    logic [7:0]  marr [int unsigned];
    logic [18:0] cap_addr = '0;
    realtime     t_fall = -1.0, t_rise = -1.0, t_oe_fall = -1.0;
    int          falls = 0;
    int          viol_addr = 0, viol_bus = 0;

    function automatic logic [7:0] mread(input logic [18:0] a);
        return marr.exists(int'(a)) ? marr[int'(a)] : dflt(a);
    endfunction

    always @(negedge mem_ce_n) if (rst_n) begin
        if (t_rise >= 0.0)
            chk(($realtime - t_rise) >= 35.0, "R3", "ce high ns", longint'($realtime - t_rise), 35);
        if (t_fall >= 0.0)
            chk(($realtime - t_fall) >= 115.0, "R3", "cycle ns", longint'($realtime - t_fall), 115);
        t_fall   = $realtime;
        cap_addr = mem_addr;
        falls++;
    end

    always @(posedge mem_ce_n) if (rst_n && t_fall >= 0.0) begin
        chk(($realtime - t_fall) >= 70.0 && ($realtime - t_fall) <= 10000.0,
            "R2", "ce low ns", longint'($realtime - t_fall), 70);
        chk(mem_oe_n === 1'b1, "R7", "oe at ce rise", mem_oe_n, 1);
        t_rise = $realtime;
    end

    always @(negedge mem_oe_n) t_oe_fall = $realtime;

    always @(posedge mem_we_n) if (rst_n && t_fall >= 0.0 && mem_ce_n === 1'b0) begin
        chk(mem_dq_oe === 1'b1, "R5", "bus driven at write end", mem_dq_oe, 1);
        marr[int'(cap_addr)] = mem_dq_out;
    end

    // Half-ns ticks stay clear of clock edges.
    initial begin
        #0.5;
        forever begin
            if (rst_n && mem_ce_n === 1'b0 && mem_addr !== cap_addr) viol_addr++;
            if (rst_n && mem_dq_oe === 1'b1 && mem_oe_n === 1'b0) viol_bus++;
            if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 &&
                ($realtime - t_fall) >= 69.0 && ($realtime - t_oe_fall) >= 24.0)
                mem_dq_in = mread(cap_addr);
            else
                mem_dq_in = ~mread(cap_addr);
            #1;
        end
    end

    // ---------------- cycle reference ----------------
    typedef struct {
        logic ce_n, we_n, oe_n, dq_oe, rsp;
        logic [7:0] dq, rd;
    } rec_t;

    rec_t exp_q[$];
    logic [7:0] exp_mem [int unsigned];
    bit checking = 0;
    bit model_idle = 0;

    function automatic rec_t idle_rec();
        rec_t r;
        r.ce_n = 1; r.we_n = 1; r.oe_n = 1; r.dq_oe = 0; r.rsp = 0; r.dq = 0; r.rd = 0;
        return r;
    endfunction

    task automatic push_access(input bit w, input bit dummy, input logic [7:0] d, input logic [7:0] rd);
        rec_t r;
        exp_q.push_back(idle_rec());
        for (int i = 0; i < NCE; i++) begin
            r = idle_rec();
            r.ce_n = 0; r.we_n = !w; r.oe_n = w || dummy; r.dq_oe = w; r.dq = d;
            exp_q.push_back(r);
        end
        r = idle_rec();
        r.ce_n = 0; r.dq_oe = w; r.dq = d; r.rsp = !w && !dummy; r.rd = rd;
        exp_q.push_back(r);
        for (int i = 0; i < NPRE; i++) exp_q.push_back(idle_rec());
    endtask

    always @(posedge clk) begin
        if (checking && model_idle && req_valid && !refresh_grant) begin
            logic [7:0] rd;
            rd = exp_mem.exists(int'(req_addr)) ? exp_mem[int'(req_addr)] : dflt(req_addr);
            if (req_write) exp_mem[int'(req_addr)] = req_wdata;
            push_access(req_write, 1'b0, req_wdata, rd);
        end
    end

    always @(posedge clk) begin
        #2;
        if (checking) begin
            rec_t r;
            bit   exp_busy;
            if (exp_q.size() > 0) begin
                r = exp_q.pop_front();
                exp_busy = 1;
            end else begin
                r = idle_rec();
                exp_busy = 0;
            end
            model_idle = !exp_busy;
            chk(mem_ce_n === r.ce_n, "R2", "ce_n", mem_ce_n, r.ce_n);
            chk(mem_we_n === r.we_n, "R5", "we_n", mem_we_n, r.we_n);
            chk(mem_oe_n === r.oe_n, "R6", "oe_n", mem_oe_n, r.oe_n);
            chk(mem_dq_oe === r.dq_oe, "R10", "dq_oe", mem_dq_oe, r.dq_oe);
            chk(rsp_valid === r.rsp, "R6", "rsp_valid", rsp_valid, r.rsp);
            chk(busy === exp_busy, "R8", "busy", busy, exp_busy);
            chk(req_ready === (!exp_busy && !refresh_grant), "R8", "req_ready",
                req_ready, (!exp_busy && !refresh_grant));
            if (r.dq_oe) chk(mem_dq_out === r.dq, "R5", "write data", mem_dq_out, r.dq);
            if (r.rsp)   chk(rsp_rdata === r.rd, "R6", "read data", rsp_rdata, r.rd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input bit w, input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        do @(posedge clk); while (!(model_idle && !refresh_grant));
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic settle();
        drop();
        @(posedge clk);
        wait (model_idle);
        @(negedge clk);
    endtask

    task automatic finish_run();
        chk(viol_addr == 0, "R4", "address moved under ce low", viol_addr, 0);
        chk(viol_bus == 0, "R10", "bus driven against outputs", viol_bus, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #1_500_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b1 && req_ready === 1'b0 && mem_ce_n === 1'b1, "R1", "reset state",
            {busy, req_ready, mem_ce_n}, 3'b101);
        rst_n = 1;
        for (int i = 0; i < NPWR - 1; i++) exp_q.push_back(idle_rec());
        for (int i = 0; i < NDUM; i++) push_access(1'b0, 1'b1, 8'h00, 8'h00);
        @(posedge clk);
        checking = 1;
        wait (model_idle);
        @(negedge clk);
        chk(falls == NDUM, "R1", "dummy pulses", falls, NDUM);

        // Reads and writes over several patterns (R5, R6, R8).
        send(0, 19'h00000, 8'h00);
        send(1, 19'h00000, 8'h3C);
        send(0, 19'h00000, 8'h00);
        send(1, 19'h7FFFF, 8'hC3);
        send(0, 19'h7FFFF, 8'h00);
        send(1, 19'h007FF, 8'h11);
        send(1, 19'h7F800, 8'h22);
        send(0, 19'h007FF, 8'h00);
        send(0, 19'h7F800, 8'h00);
        send(0, 19'h12345, 8'h00);
        settle();

        // R9: grant held before a request arrives.
        refresh_grant = 1;
        f0 = falls;
        fork
            send(1, 19'h2AAAA, 8'h5A);
            begin
                repeat (6) @(negedge clk);
                chk(falls == f0, "R9", "ce fall under grant", falls - f0, 0);
                chk(req_ready === 1'b0, "R9", "ready under grant", req_ready, 0);
                refresh_grant = 0;
            end
        join
        settle();

        // R9: grant rises just as the sequencer returns to idle with a request waiting.
        send(1, 19'h05555, 8'hA5);
        @(negedge clk);
        req_write = 0; req_addr = 19'h05555;
        repeat (NCE + NPRE) @(negedge clk);
        refresh_grant = 1;
        f0 = falls;
        repeat (8) @(negedge clk);
        chk(falls == f0, "R9", "ce fall at collision", falls - f0, 0);
        refresh_grant = 0;
        do @(posedge clk); while (!model_idle);
        settle();
        chk(falls == f0 + 1, "R8", "one pulse per request", falls - f0, 1);

        send(0, 19'h2AAAA, 8'h00);
        settle();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule